// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This unit is a processor-side timer built from two 32-bit registers: a count that climbs by one on every tick, and a compare value. When a tick carries the count onto the compare value, the unit latches a pending timer interrupt. The pending interrupt drives one of eight interrupt lines, and a 3-bit routing field picks which line. The interrupt stays pending until software writes the compare register. That write is the only acknowledge, and the value written does not matter.

Software reaches the unit through a single-cycle register port with four word addresses. A freeze bit in the control word stops the count so that software can inspect it or reload it. No match can fire while the count is frozen. Ticks come from a prescaler: one tick every `PRESCALE` clock cycles, two by default. Loading the count restarts the prescaler phase. The pending bit can be read back only when the `HAS_STATUS` parameter is set. The interrupt line is driven whatever the parameter value.

Top module: `cmp_timer_irq`

## Requirements
- R1: After synchronous reset the count, compare, control word and pending bit all read 0, counting is enabled and every interrupt line is low.
- R2: Address 0 is the count. A write loads the written value and restarts the prescaler. With freeze clear, the count then reads `value + floor(k / PRESCALE)` k cycles after the write edge, and it wraps modulo 2^32.
- R3: Address 2 is the control word, with bit 0 freeze and bits 3:1 route. While freeze is 1 the count holds its value. A count write during that time loads the new value directly, and reads return the held value.
- R4: When a tick moves the count onto the compare value (address 1), the pending bit sets. It stays set after the count moves past the match value.
- R5: Any write to address 1 clears the pending bit and drops the interrupt line on that same clock edge, whatever the data.
- R6: While an interrupt is pending exactly one line is high, `irq_lines[route]`. With nothing pending all lines are low.
- R7: While freeze is 1 no match can set the pending bit, even when the count already sits one below compare.
- R8: A match needs a tick that arrives at the compare value. Loading compare equal to the current count, or loading the count equal to compare, raises nothing until the count gets back to that value by counting.
- R9: If a compare write and a matching tick occur on the same edge, the write wins and the interrupt stays clear.
- R10: Address 3 reads the pending bit in bit 0 only when `HAS_STATUS` is 1, and reads 0 otherwise. Interrupt lines are driven in both cases. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe, single cycle |
| reg_addr | input | 2 | Register word address: 0 count, 1 compare, 2 control, 3 status |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Combinational read data for reg_addr |
| irq_lines | output | 8 | Routed timer interrupt lines |

## Verification
The count is read after every cycle of a window that follows a load. This shows whether it steps once per prescale period, and across the 2^32 wrap it shows whether it wraps. Each of the eight routing values is swept through a full match, hold and acknowledge cycle: the one-hot line pattern reveals routing errors, and a read taken one cycle before the match catches early or late firing. Further patterns time a compare write onto the matching edge, park the count one below compare while frozen, and set compare equal to a frozen count. These separate a correct edge-triggered match from a level compare, and a correct write-wins rule from a match-wins rule. A second instance built without the status bit shows that its line still rises while its status reads zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ROUTE_W   = 3;
    localparam int NUM_LINES = 1 << ROUTE_W;

    typedef enum logic [1:0] {
        REG_COUNT   = 2'd0,
        REG_COMPARE = 2'd1,
        REG_CTRL    = 2'd2,
        REG_STATUS  = 2'd3
    } tmr_reg_e;

    typedef struct packed {
        logic [ROUTE_W-1:0] route;
        logic               freeze;
    } tmr_ctrl_t;

    function automatic logic [NUM_LINES-1:0] route_onehot(input logic [ROUTE_W-1:0] sel);
        logic [NUM_LINES-1:0] v;
        v = '0;
        v[sel] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int PRESCALE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] phase;

            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    phase <= '0;
                end else if (run) begin
                    phase <= (phase == LAST) ? '0 : phase + 1'b1;
                end
            end

            assign tick = run && (phase == LAST);
        end
    endgenerate
endmodule

// File: rtl/tmr_count_reg.sv
module tmr_count_reg #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_load,
    input  logic             cmp_load,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] compare_q,
    output logic             match
);
    logic [CNT_W-1:0] count_next;

    assign count_next = count_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (cnt_load) begin
            count_q <= wdata;
        end else if (tick) begin
            count_q <= count_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            compare_q <= '0;
        end else if (cmp_load) begin
            compare_q <= wdata;
        end
    end

    // A match is an arrival: the tick must be the one that lands on compare.
    assign match = tick && !cnt_load && (count_next == compare_q);
endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch
    import tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 match,
    input  logic                 ack,
    input  logic [ROUTE_W-1:0]   route,
    output logic                 pending,
    output logic [NUM_LINES-1:0] lines
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (ack) begin
            pending <= 1'b0;     // acknowledge beats a simultaneous match
        end else if (match) begin
            pending <= 1'b1;
        end
    end

    assign lines = pending ? route_onehot(route) : '0;
endmodule

// File: rtl/cmp_timer_irq.sv
module cmp_timer_irq
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int PRESCALE   = 2,
    parameter bit HAS_STATUS = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [CNT_W-1:0]     reg_wdata,
    output logic [CNT_W-1:0]     reg_rdata,
    output logic [NUM_LINES-1:0] irq_lines
);
    localparam int CTRL_W = $bits(tmr_ctrl_t);

    tmr_reg_e         addr_e;
    tmr_ctrl_t        ctrl_q;
    logic             wr_count, wr_compare, wr_ctrl;
    logic             tick, match, pending, freeze_q;
    logic [CNT_W-1:0] count_q, compare_q;

    assign addr_e     = tmr_reg_e'(reg_addr);
    assign wr_count   = reg_we && (addr_e == REG_COUNT);
    assign wr_compare = reg_we && (addr_e == REG_COMPARE);
    assign wr_ctrl    = reg_we && (addr_e == REG_CTRL);
    assign freeze_q   = ctrl_q.freeze;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= tmr_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    tmr_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (!ctrl_q.freeze),
        .restart (wr_count),
        .tick    (tick)
    );

    tmr_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cnt_load  (wr_count),
        .cmp_load  (wr_compare),
        .wdata     (reg_wdata),
        .count_q   (count_q),
        .compare_q (compare_q),
        .match     (match)
    );

    tmr_irq_latch u_irq (
        .clk     (clk),
        .rst     (rst),
        .match   (match),
        .ack     (wr_compare),
        .route   (ctrl_q.route),
        .pending (pending),
        .lines   (irq_lines)
    );

    logic status_bit;
    generate
        if (HAS_STATUS) begin : g_status
            assign status_bit = pending;
        end else begin : g_no_status
            assign status_bit = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (addr_e)
            REG_COUNT:   reg_rdata = count_q;
            REG_COMPARE: reg_rdata = compare_q;
            REG_CTRL:    reg_rdata = CNT_W'(ctrl_q);
            default:     reg_rdata = CNT_W'(status_bit);
        endcase
    end
endmodule

// File: rtl/cmp_timer_irq_chk.sv
module cmp_timer_irq_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_we,
    input logic [1:0]           reg_addr,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic [CNT_W-1:0]     count_q,
    input logic                 freeze_q
);
    logic cnt_wr, cmp_wr;
    assign cnt_wr = reg_we && (reg_addr == REG_COUNT);
    assign cmp_wr = reg_we && (reg_addr == REG_COMPARE);

    assert_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_lines));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_lines != '0) && !cmp_wr |=> (irq_lines != '0));

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
        cmp_wr |=> (irq_lines == '0));

    assert_freeze_holds_R3: assert property (@(posedge clk) disable iff (rst)
        freeze_q && !cnt_wr |=> $stable(count_q));

    assert_no_match_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        freeze_q && (irq_lines == '0) |=> (irq_lines == '0));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + CNT_W'(1)));
endmodule

bind cmp_timer_irq cmp_timer_irq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .irq_lines (irq_lines),
    .count_q   (count_q),
    .freeze_q  (freeze_q)
);

// File: tb/cmp_timer_irq_tb.sv
`timescale 1ns/1ps
module cmp_timer_irq_tb;
    localparam int W = 32;
    localparam int P = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] rdata, rdata_ns;
    logic [7:0]   irq, irq_ns;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_timer_irq #(.CNT_W(W), .PRESCALE(P), .HAS_STATUS(1'b1)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .irq_lines(irq));

    cmp_timer_irq #(.CNT_W(W), .PRESCALE(P), .HAS_STATUS(1'b0)) u_dut_nost (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_ns), .irq_lines(irq_ns));

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Starts and ends at a falling edge; exactly one rising edge performs the write.
    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        @(negedge clk);
    endtask

    // No clock edge passes during a read.
    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        reg_addr = a; #0.5;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] v, c0;
        idle(3);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq", W'(irq), '0);
        rd(2'd1, v); check("R1 compare", v, '0);
        rd(2'd2, v); check("R1 ctrl", v, '0);
        rd(2'd3, v); check("R1 status", v, '0);

        // R2: count load and prescaled stepping
        wr(2'd0, 32'd100);
        for (int k = 0; k < 10; k++) begin
            rd(2'd0, v); check("R2 count step", v, W'(100 + k / P));
            idle(1);
        end

        // R3: freeze holds, loads directly, then resumes
        wr(2'd2, 32'd1);
        rd(2'd0, c0);
        idle(10);
        rd(2'd0, v); check("R3 held", v, c0);
        wr(2'd0, 32'd777);
        idle(7);
        rd(2'd0, v); check("R3 frozen load", v, 32'd777);
        wr(2'd2, 32'd0);
        idle(6);
        rd(2'd0, v); check("R3 resume", v, 32'd780);

        // R4 R5 R6: full match cycle on every route
        for (int r = 0; r < 8; r++) begin
            logic [W-1:0] c;
            c = W'(1000 + r * 37);
            wr(2'd2, W'(r << 1));
            wr(2'd1, c);
            wr(2'd0, c - 3);
            idle(5);
            check("R4 no early match", W'(irq), '0);
            idle(1);
            check("R6 routed line", W'(irq), W'(1 << r));
            rd(2'd3, v); check("R4 status set", v, 32'd1);
            check("R10 no-status line", W'(irq_ns), W'(1 << r));
            reg_addr = 2'd3; #0.5;
            check("R10 no-status read", rdata_ns, '0);
            idle(10);
            check("R4 sticky past match", W'(irq), W'(1 << r));
            wr(2'd1, W'(32'hA5A5_0000 + r));
            check("R5 ack clears", W'(irq), '0);
            rd(2'd3, v); check("R5 status cleared", v, '0);
        end

        // R7: frozen one below compare never fires
        wr(2'd2, 32'd1);
        wr(2'd0, 32'd4999);
        wr(2'd1, 32'd5000);
        idle(20);
        check("R7 frozen no irq", W'(irq), '0);
        rd(2'd0, v); check("R7 count held", v, 32'd4999);
        wr(2'd2, 32'd0);
        idle(2);
        check("R7 fires once unfrozen", W'(irq), W'(1));
        wr(2'd1, 32'd0);

        // R8: compare set equal to current count
        wr(2'd2, 32'd1);
        wr(2'd0, 32'd50);
        wr(2'd1, 32'd50);
        wr(2'd2, 32'd0);
        idle(20);
        check("R8 equal no fire", W'(irq), '0);
        rd(2'd0, v); check("R8 count moved", v, 32'd60);

        // R2 R4: wrap and match across wrap on route 5
        wr(2'd2, 32'd10);
        wr(2'd1, 32'd1);
        wr(2'd0, 32'hFFFF_FFFE);
        idle(2);
        rd(2'd0, v); check("R2 pre-wrap", v, 32'hFFFF_FFFF);
        idle(2);
        rd(2'd0, v); check("R2 wrapped", v, 32'd0);
        check("R4 not yet", W'(irq), '0);
        idle(2);
        check("R4 match after wrap", W'(irq), W'(1 << 5));

        // R9: compare write on the matching edge wins
        wr(2'd1, 32'd3000);
        wr(2'd0, 32'd2997);
        idle(5);
        wr(2'd1, 32'd3000);
        check("R9 write wins", W'(irq), '0);
        rd(2'd0, v); check("R9 count reached", v, 32'd3000);
        idle(8);
        check("R9 stays clear", W'(irq), '0);

        // R10: status writes ignored
        wr(2'd3, '1);
        rd(2'd3, v); check("R10 status write ignored", v, '0);
        check("R10 irq unaffected", W'(irq), '0);
        rd(2'd2, v); check("R10 ctrl unaffected", v, 32'd10);

        finish_run();
    end
endmodule